// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Detector

This block watches the receive queue of a serial port and tells the interrupt logic when characters have been left unread for too long. A character that arrives and is then followed by silence on the line might never reach the host if the host waits only for a fill-level interrupt. The detector closes that gap. It counts 16x baud ticks while the queue holds data. It restarts the count whenever a new character lands or the host pops one. When the count covers four whole character times at the programmed frame format, it raises a pending flag.

The window follows the frame format. One character time is 1 start bit, 5 to 8 data bits, an optional parity bit and 1 or 2 stop bits. So the window spans 448 to 768 oversampled ticks. With 8 data bits, parity and 2 stop bits at 1200 baud, this gives 768 ticks at 19200 Hz, which is 40 ms.

Control is a three-state machine:
- `ST_IDLE`: the queue is empty or disabled.
- `ST_ARMED`: counting.
- `ST_EXPIRED`: the timeout is pending.

The transitions are:
- *arm*: IDLE to ARMED, when the queue is enabled and holds data.
- *restart*: ARMED to ARMED, on a received character or a host read.
- *expire*: ARMED to EXPIRED, when the count reaches the window.
- *acknowledge*: EXPIRED to ARMED, on a host read.
- *drain*: any state to IDLE, when the queue is empty or disabled.

Top module: `rxfifo_idle_timeout`

## Requirements
- R1: `timeout_pend` is never set while `fifo_nonempty` is low or `fifo_en` is low. When the queue empties, the flag clears on the next clock.
- R2: A `char_rcvd` pulse restarts the window. After it, a full window of ticks is needed before expiry. A tick in the same cycle as the pulse is not counted.
- R3: A `host_read` pulse restarts the window. A read in the same cycle as the tick that would complete the window prevents the timeout.
- R4: The window length in `baud16_tick` pulses is 64 × (1 + (5 + `data_len_sel`) + `parity_on` + 1 + `stop_two`). `data_len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R5: `timeout_pend` stays low after one tick fewer than the window. It rises within two clock cycles after the tick that completes the window.
- R6: A `host_read` while the timeout is pending clears `timeout_pend` on the next clock. If data remains, a new full window is counted.
- R7: After expiry the tick count holds at its terminal value and does not wrap. `timeout_pend` stays set through any number of further ticks.
- R8: Reset, or `fifo_en` low, clears both the pending flag and the tick count. After that, a full window is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | Receive queue enabled |
| fifo_nonempty | input | 1 | Receive queue holds at least one character |
| char_rcvd | input | 1 | One-cycle pulse per character written into the queue |
| host_read | input | 1 | One-cycle pulse per host read of the queue |
| baud16_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| data_len_sel | input | 2 | Data bits: 0..3 select 5..8 |
| parity_on | input | 1 | Parity bit present in the frame |
| stop_two | input | 1 | Two stop bits instead of one |
| timeout_pend | output | 1 | Idle timeout pending, toward interrupt logic |

## Verification
Two functions can land in the same cycle: the oversampled tick that would complete the window, and a host read that restarts it. The bench counts one tick fewer than the window and then drives that final tick in the same cycle as `host_read`. The read must win. The flag must stay low, and exactly one further full window must be needed before it rises. A second collision drives a tick together with `char_rcvd`; that tick must not count toward the new window.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_EXPIRED = 2'd2
    } rxto_state_e;

    localparam int unsigned START_BITS = 1;
    localparam int unsigned MIN_DATA   = 5;
    localparam int unsigned MIN_STOP   = 1;
    localparam int unsigned MAX_FRAME  = START_BITS + MIN_DATA + 3 + 1 + MIN_STOP + 1;

    function automatic int unsigned frame_bits(input logic [1:0] len_sel,
                                               input logic       par,
                                               input logic       stop2);
        return START_BITS + MIN_DATA + 32'(len_sel) + 32'(par) + MIN_STOP + 32'(stop2);
    endfunction

endpackage

// File: rtl/rxto_window_calc.sv
module rxto_window_calc
    import rxto_pkg::*;
#(
    parameter int unsigned OVERSAMPLE   = 16,
    parameter int unsigned WINDOW_CHARS = 4,
    parameter int unsigned CNT_W        = 10
) (
    input  logic [1:0]       data_len_sel,
    input  logic             parity_on,
    input  logic             stop_two,
    output logic [CNT_W-1:0] limit
);

    localparam int unsigned TICKS_PER_BIT_WIN = OVERSAMPLE * WINDOW_CHARS;

    always_comb begin
        limit = CNT_W'(TICKS_PER_BIT_WIN * frame_bits(data_len_sel, parity_on, stop_two));
    end

endmodule

// File: rtl/rxto_tick_counter.sv
module rxto_tick_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    // Clear wins over a coincident tick; saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt >= limit);

endmodule

// File: rtl/rxto_ctrl_fsm.sv
module rxto_ctrl_fsm
    import rxto_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic        fifo_nonempty,
    input  logic        char_rcvd,
    input  logic        host_read,
    input  logic        cnt_done,
    output rxto_state_e state,
    output logic        pend,
    output logic        cnt_clr
);

    rxto_state_e state_q;
    rxto_state_e state_d;
    logic        active;
    logic        restart;

    assign active  = fifo_en && fifo_nonempty;
    assign restart = char_rcvd || host_read;

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_ARMED;
                ST_ARMED:   begin
                    if (restart)       state_d = ST_ARMED;
                    else if (cnt_done) state_d = ST_EXPIRED;
                end
                ST_EXPIRED: begin
                    if (host_read) state_d = ST_ARMED;
                end
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend    = (state_q == ST_EXPIRED);
        cnt_clr = restart || !active || (state_q == ST_IDLE);
        state   = state_q;
    end

endmodule

// File: rtl/rxfifo_idle_timeout.sv
module rxfifo_idle_timeout
    import rxto_pkg::*;
#(
    parameter int unsigned OVERSAMPLE   = 16,
    parameter int unsigned WINDOW_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       fifo_nonempty,
    input  logic       char_rcvd,
    input  logic       host_read,
    input  logic       baud16_tick,
    input  logic [1:0] data_len_sel,
    input  logic       parity_on,
    input  logic       stop_two,
    output logic       timeout_pend
);

    localparam int unsigned MAX_WINDOW = OVERSAMPLE * WINDOW_CHARS * MAX_FRAME;
    localparam int unsigned CNT_W      = $clog2(MAX_WINDOW + 1);

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             cnt_done;
    logic             cnt_clr;
    rxto_state_e      state;

    rxto_window_calc #(
        .OVERSAMPLE  (OVERSAMPLE),
        .WINDOW_CHARS(WINDOW_CHARS),
        .CNT_W       (CNT_W)
    ) u_win (
        .data_len_sel(data_len_sel),
        .parity_on   (parity_on),
        .stop_two    (stop_two),
        .limit       (limit)
    );

    rxto_tick_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .tick (baud16_tick),
        .limit(limit),
        .cnt  (cnt),
        .done (cnt_done)
    );

    rxto_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .fifo_nonempty(fifo_nonempty),
        .char_rcvd    (char_rcvd),
        .host_read    (host_read),
        .cnt_done     (cnt_done),
        .state        (state),
        .pend         (timeout_pend),
        .cnt_clr      (cnt_clr)
    );

endmodule

// File: rtl/rxfifo_idle_timeout_chk.sv
module rxfifo_idle_timeout_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             fifo_nonempty,
    input logic             char_rcvd,
    input logic             host_read,
    input logic             timeout_pend,
    input logic             cnt_clr,
    input logic             cnt_done,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit
);

    // R1
    pend_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pend |-> $past(fifo_en && fifo_nonempty));

    // R2
    char_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_rcvd |=> (cnt == '0));

    // R3
    read_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_read |=> ((cnt == '0) && !timeout_pend));

    // R5
    rise_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> $past(cnt_done));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt >= limit) && !cnt_clr) |=> (cnt == $past(cnt)));

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> (!timeout_pend && (cnt == '0)));

endmodule

bind rxfifo_idle_timeout rxfifo_idle_timeout_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .fifo_nonempty(fifo_nonempty),
    .char_rcvd    (char_rcvd),
    .host_read    (host_read),
    .timeout_pend (timeout_pend),
    .cnt_clr      (cnt_clr),
    .cnt_done     (cnt_done),
    .cnt          (cnt),
    .limit        (limit)
);

// File: tb/rxfifo_idle_timeout_tb_top.sv
`timescale 1ns/1ps
module rxfifo_idle_timeout_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       fifo_nonempty = 1'b0;
    logic       char_rcvd = 1'b0;
    logic       host_read = 1'b0;
    logic       baud16_tick = 1'b0;
    logic [1:0] data_len_sel = 2'd3;
    logic       parity_on = 1'b1;
    logic       stop_two = 1'b1;
    logic       timeout_pend;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    rxfifo_idle_timeout dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .fifo_nonempty(fifo_nonempty),
        .char_rcvd    (char_rcvd),
        .host_read    (host_read),
        .baud16_tick  (baud16_tick),
        .data_len_sel (data_len_sel),
        .parity_on    (parity_on),
        .stop_two     (stop_two),
        .timeout_pend (timeout_pend)
    );

    function automatic int win_ticks();
        return 64 * (1 + 5 + int'(data_len_sel) + int'(parity_on) + 1 + int'(stop_two));
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: timeout_pend actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); baud16_tick = 1'b1;
            @(negedge clk); baud16_tick = 1'b0;
        end
    endtask

    task automatic pulse_char();
        @(negedge clk); char_rcvd = 1'b1;
        @(negedge clk); char_rcvd = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); host_read = 1'b1;
        @(negedge clk); host_read = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic arm_with_char();
        @(negedge clk); fifo_en = 1'b1; fifo_nonempty = 1'b1;
        pulse_char();
        idle(1);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R8 reset state", timeout_pend, 1'b0);
    endtask

    task automatic t_expire(input logic [1:0] ls, input logic p, input logic s2, input string tag);
        do_reset();
        data_len_sel = ls; parity_on = p; stop_two = s2;
        arm_with_char();
        ticks(win_ticks() - 1);
        idle(3);
        chk({"R5 one tick short ", tag}, timeout_pend, 1'b0);
        ticks(1);
        idle(2);
        chk({"R4 window expired ", tag}, timeout_pend, 1'b1);
    endtask

    task automatic t_empty();
        do_reset();
        @(negedge clk); fifo_en = 1'b1; fifo_nonempty = 1'b0;
        ticks(900);
        idle(3);
        chk("R1 empty queue no timeout", timeout_pend, 1'b0);
        arm_with_char();
        ticks(win_ticks());
        idle(2);
        chk("R1 setup pending", timeout_pend, 1'b1);
        @(negedge clk); fifo_nonempty = 1'b0;
        idle(1);
        chk("R1 drain clears", timeout_pend, 1'b0);
    endtask

    task automatic t_char_restart();
        do_reset();
        arm_with_char();
        ticks(win_ticks() - 5);
        pulse_char();
        ticks(win_ticks() - 1);
        idle(3);
        chk("R2 char restarts window", timeout_pend, 1'b0);
        ticks(1);
        idle(2);
        chk("R2 expiry after full window", timeout_pend, 1'b1);
    endtask

    task automatic t_read_restart();
        do_reset();
        arm_with_char();
        ticks(win_ticks() - 5);
        pulse_read();
        ticks(win_ticks() - 1);
        idle(3);
        chk("R3 read restarts window", timeout_pend, 1'b0);
        ticks(1);
        idle(2);
        chk("R3 expiry after full window", timeout_pend, 1'b1);
    endtask

    task automatic t_collision();
        do_reset();
        arm_with_char();
        ticks(win_ticks() - 1);
        @(negedge clk); baud16_tick = 1'b1; host_read = 1'b1;
        @(negedge clk); baud16_tick = 1'b0; host_read = 1'b0;
        idle(3);
        chk("R3 read beats final tick", timeout_pend, 1'b0);
        ticks(win_ticks() - 1);
        idle(3);
        chk("R3 window restarted after collision", timeout_pend, 1'b0);
        ticks(1);
        idle(2);
        chk("R3 expiry after collision", timeout_pend, 1'b1);
        pulse_read();
        @(negedge clk); baud16_tick = 1'b1; char_rcvd = 1'b1;
        @(negedge clk); baud16_tick = 1'b0; char_rcvd = 1'b0;
        ticks(win_ticks() - 1);
        idle(3);
        chk("R2 coincident tick not counted", timeout_pend, 1'b0);
    endtask

    task automatic t_ack_and_hold();
        do_reset();
        arm_with_char();
        ticks(win_ticks());
        idle(2);
        ticks(1500);
        idle(2);
        chk("R7 holds through further ticks", timeout_pend, 1'b1);
        @(negedge clk); host_read = 1'b1;
        @(negedge clk); host_read = 1'b0;
        chk("R6 read clears next clock", timeout_pend, 1'b0);
        ticks(win_ticks() - 1);
        idle(3);
        chk("R6 new window counted", timeout_pend, 1'b0);
        ticks(1);
        idle(2);
        chk("R6 re-expires", timeout_pend, 1'b1);
    endtask

    task automatic t_disable();
        do_reset();
        arm_with_char();
        ticks(win_ticks());
        idle(2);
        @(negedge clk); fifo_en = 1'b0;
        idle(1);
        chk("R8 disable clears pending", timeout_pend, 1'b0);
        @(negedge clk); fifo_en = 1'b1;
        ticks(win_ticks() - 1);
        idle(3);
        chk("R8 count restarted after disable", timeout_pend, 1'b0);
        ticks(1);
        idle(2);
        chk("R8 expiry after re-enable", timeout_pend, 1'b1);
        arm_with_char();
        ticks(win_ticks() / 2);
        do_reset();
        fifo_en = 1'b1; fifo_nonempty = 1'b1;
        ticks(win_ticks() - 1);
        idle(3);
        chk("R8 reset clears count", timeout_pend, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_expire(2'd3, 1'b1, 1'b1, "8O2");
        t_expire(2'd0, 1'b0, 1'b0, "5N1");
        t_expire(2'd2, 1'b1, 1'b0, "7P1");
        t_empty();
        t_char_restart();
        t_read_restart();
        t_collision();
        t_ack_and_hold();
        t_disable();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule